// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Control

This block is one 8-bit general-purpose I/O port. It sits on a simple synchronous register bus with an address, a write strobe, a read strobe, write data and read data. Two registers sit at fixed offsets from a relocatable base address that arrives as an input. The output-level register sets the value driven onto each pin. The direction register sets which pins are driven at all. The block sends a per-pin output enable and a per-pin output value to tri-state pad buffers outside it. Pad inputs pass through a multi-stage synchronizer before any read can see them.

Reads of the output-level register are mixed bit by bit. A pin set as an output returns the stored level. A pin set as an input returns the synchronized pad state. A mode input tells the block whether the chip runs self-contained or uses an external bus (expanded or peripheral operation). In external-bus operation both port registers leave the local map. An access to their addresses is then not decoded locally: it raises an external-access request in the same cycle, and the external bus logic handles it.

Top module: `gpio_port`

## Requirements
- R1: A pin whose direction bit is 1 has `pad_oe` high and drives the matching bit of the output-level register on `pad_out`.
- R2: A pin whose direction bit is 0 has `pad_oe` low, so the pin is left undriven.
- R3: While `rst` is high and after it falls, the direction register and the output-level register both hold 0x00, so `pad_oe` and `pad_out` are 0x00.
- R4: A read of the output-level register returns, for each bit, the stored level when the direction bit is 1 and the synchronized pad input when it is 0.
- R5: A change on `pad_in` becomes visible to reads two clock edges after it is applied. A read in the same cycle as the change, or in the cycle after it, still returns the old pad value.
- R6: The output-level register sits at `base_addr + 0` and the direction register at `base_addr + 2`. Moving `base_addr` moves both registers. In self-contained mode (`mode` = 2'b00) both can be read and written at any time.
- R7: The output-level register accepts writes whatever the direction bits are, so a level can be preloaded while a pin is still an input.
- R8: When `mode` is not 2'b00, a read or write at offset 0 or 2 raises `ext_req` in the same cycle. Such a read returns 0x00. Such a write changes neither register.
- R9: A read at offset 1 or 3, or at any address outside the four-byte window, returns 0x00 and leaves `ext_req` low. A write there changes no register.
- R10: A register write takes effect at the clock edge that ends the write cycle. Read data is combinational from the current register and synchronizer state in the cycle of the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 2'b00 self-contained; any other value selects external-bus operation |
| base_addr | input | 16 | Base address of the port's register window |
| bus_addr | input | 16 | Register bus address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ext_req | output | 1 | Access forwarded to the external bus |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pin output enable to the pad buffers |
| pad_out | output | 8 | Per-pin output value to the pad buffers |

## Verification
The bench sets mixed direction patterns and checks that each read bit follows its own direction bit. A design that selected the readback source once for the whole port would return the pad value where the stored level belongs, or the reverse. The bench changes a pad and reads it in each of the next three cycles. This catches a synchronizer that is too short, which shows the new value early, or too long, which shows it late. Under each non-self-contained mode it writes ones to both registers and checks that `pad_oe` and `pad_out` stay the same and that `ext_req` rises. A design still decoding locally would switch pins to outputs. The bench also probes the holes at offsets 1 and 3, the address just past the window, and a moved base, where a loose decoder would alias onto a real register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W      = 8;
    localparam int ADDR_W      = 16;
    localparam int SYNC_STAGES = 2;
    localparam int WIN_SIZE    = 4;
    localparam int OFS_LEVEL   = 0;
    localparam int OFS_DIR     = 2;

    typedef enum logic [1:0] {
        MODE_SELF     = 2'b00,
        MODE_EXP_NARR = 2'b01,
        MODE_EXP_WIDE = 2'b10,
        MODE_PERIPH   = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LEVEL = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_HOLE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     rd;
        logic     wr;
    } access_t;

    function automatic logic map_is_local(input bus_mode_e m);
        return (m == MODE_SELF);
    endfunction

    function automatic logic sel_is_real(input reg_sel_e s);
        return (s == SEL_LEVEL) || (s == SEL_DIR);
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic          bus_re,
    output access_t       acc,
    output logic          ext_req
);
    localparam logic [AW-1:0] WIN_LIM = AW'(WIN_SIZE);
    localparam logic [AW-1:0] O_LEVEL = AW'(OFS_LEVEL);
    localparam logic [AW-1:0] O_DIR   = AW'(OFS_DIR);

    logic [AW-1:0] ofs;
    logic          in_win;
    logic          local_map;
    reg_sel_e      sel;

    always_comb begin
        ofs       = bus_addr - base_addr;
        in_win    = (ofs < WIN_LIM);
        local_map = map_is_local(bus_mode_e'(mode));
        if (!in_win)             sel = SEL_NONE;
        else if (ofs == O_LEVEL) sel = SEL_LEVEL;
        else if (ofs == O_DIR)   sel = SEL_DIR;
        else                     sel = SEL_HOLE;

        acc.sel = sel;
        acc.rd  = bus_re && local_map;
        acc.wr  = bus_we && local_map && sel_is_real(sel);
        ext_req = (bus_we || bus_re) && !local_map && sel_is_real(sel);
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  access_t      acc,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] level_q,
    output logic [W-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            dir_q   <= '0;
        end else if (acc.wr) begin
            if (acc.sel == SEL_LEVEL) level_q <= wdata;
            if (acc.sel == SEL_DIR)   dir_q   <= wdata;
        end
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  access_t      acc,
    input  logic [W-1:0] level_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rdata
);
    logic [W-1:0] mixed;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign mixed[b] = dir_q[b] ? level_q[b] : pin_sync[b];
    end

    always_comb begin
        rdata = '0;
        if (acc.rd) begin
            case (acc.sel)
                SEL_LEVEL: rdata = mixed;
                SEL_DIR:   rdata = dir_q;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PW  = PORT_W,
    parameter int AW  = ADDR_W,
    parameter int SYN = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [PW-1:0] bus_wdata,
    output logic [PW-1:0] bus_rdata,
    output logic          ext_req,
    input  logic [PW-1:0] pad_in,
    output logic [PW-1:0] pad_oe,
    output logic [PW-1:0] pad_out
);
    access_t       acc;
    logic [PW-1:0] level_q;
    logic [PW-1:0] dir_q;
    logic [PW-1:0] pin_sync;

    gpio_addr_decode #(.AW(AW)) u_dec (
        .mode(mode), .base_addr(base_addr), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_re(bus_re), .acc(acc), .ext_req(ext_req)
    );

    gpio_in_sync #(.W(PW), .STAGES(SYN)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
    );

    gpio_regs #(.W(PW)) u_regs (
        .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata),
        .level_q(level_q), .dir_q(dir_q)
    );

    gpio_read_mux #(.W(PW)) u_rmux (
        .acc(acc), .level_q(level_q), .dir_q(dir_q),
        .pin_sync(pin_sync), .rdata(bus_rdata)
    );

    assign pad_oe  = dir_q;
    assign pad_out = level_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int PW = 8,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode,
    input logic [AW-1:0] base_addr,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic          bus_re,
    input logic [PW-1:0] bus_wdata,
    input logic [PW-1:0] bus_rdata,
    input logic          ext_req,
    input logic [PW-1:0] pad_oe,
    input logic [PW-1:0] pad_out
);
    logic [AW-1:0] rel;
    assign rel = bus_addr - base_addr;

    // R3
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && pad_out == '0));

    // R1
    dir_write_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && bus_we && rel == AW'(2)) |=> pad_oe == $past(bus_wdata));

    // R7
    level_write_out_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && bus_we && rel == AW'(0)) |=> pad_out == $past(bus_wdata));

    // R8
    ext_only_remote_chk: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> mode != 2'b00);

    // R8
    remote_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00 && bus_we) |=> ($stable(pad_oe) && $stable(pad_out)));

    // R9
    hole_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && (rel == AW'(1) || rel == AW'(3) || rel >= AW'(4)))
            |-> (bus_rdata == '0 && !ext_req));
endmodule

bind gpio_port gpio_port_chk #(.PW(PW), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .base_addr(base_addr),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_req(ext_req),
    .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [15:0] base_addr = 16'h0040;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ext_req;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        logic [7:0] data;
        logic       ext;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst(rst), .mode(mode), .base_addr(base_addr),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_req(ext_req),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read results and compares them mid-cycle.
    always @(negedge clk) begin
        if (bus_re) begin
            if (sb_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard: read with no expectation, actual %02h expected none", bus_rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " rdata"}, bus_rdata, e.data);
                check({e.tag, " ext_req"}, {7'd0, ext_req}, {7'd0, e.ext});
            end
        end
    end

    // All tasks start and end at one time unit after a rising edge.
    task automatic bus_rd(input logic [15:0] ofs, input logic [7:0] exp,
                          input logic ext, input string tag);
        exp_t e;
        e.data = exp; e.ext = ext; e.tag = tag;
        sb_q.push_back(e);
        bus_addr = base_addr + ofs;
        bus_re   = 1'b1;
        @(posedge clk); #1;
        bus_re   = 1'b0;
    endtask

    task automatic bus_wr(input logic [15:0] ofs, input logic [7:0] d,
                          input logic ext, input string tag);
        bus_addr  = base_addr + ofs;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        check({tag, " write ext_req"}, {7'd0, ext_req}, {7'd0, ext});
        @(posedge clk); #1;
        bus_we    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        // R3: state held during reset
        check("R3 oe in reset", pad_oe, 8'h00);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R3 oe after reset", pad_oe, 8'h00);
        check("R3 out after reset", pad_out, 8'h00);
        bus_rd(16'd2, 8'h00, 1'b0, "R3 dir reset");

        // R7: preload level while all pins are inputs; R2 no pin driven
        pad_in = 8'h3C;
        bus_wr(16'd0, 8'hA5, 1'b0, "R7 preload");
        check("R7 pad_out preloaded", pad_out, 8'hA5);
        check("R2 oe still off", pad_oe, 8'h00);
        @(posedge clk); #1; @(posedge clk); #1;
        bus_rd(16'd0, 8'h3C, 1'b0, "R4 all inputs read pads");

        // R1/R10: switch upper nibble to output
        bus_addr = base_addr + 16'd2; bus_wdata = 8'hF0; bus_we = 1'b1;
        #1 check("R10 oe before edge", pad_oe, 8'h00);
        @(posedge clk); #1; bus_we = 1'b0;
        check("R1 R10 oe after edge", pad_oe, 8'hF0);
        bus_rd(16'd2, 8'hF0, 1'b0, "R6 dir readback");
        // R4: upper from level A, lower from pads C
        bus_rd(16'd0, 8'hAC, 1'b0, "R4 mixed F0");
        bus_wr(16'd2, 8'h5A, 1'b0, "R1 dir 5A");
        check("R1 oe 5A", pad_oe, 8'h5A);
        // level A5 & 5A = 00 ; pads 3C & A5 = 24
        bus_rd(16'd0, 8'h24, 1'b0, "R4 mixed 5A");

        // R5: pad change latency
        bus_wr(16'd2, 8'h00, 1'b0, "R2 all inputs");
        check("R2 oe cleared", pad_oe, 8'h00);
        pad_in = 8'hC3;
        bus_rd(16'd0, 8'h3C, 1'b0, "R5 same cycle old");
        bus_rd(16'd0, 8'h3C, 1'b0, "R5 one edge old");
        bus_rd(16'd0, 8'hC3, 1'b0, "R5 two edges new");

        // R9: holes and outside window
        bus_wr(16'd1, 8'hFF, 1'b0, "R9 hole1 write");
        bus_wr(16'd3, 8'hFF, 1'b0, "R9 hole3 write");
        bus_wr(16'd4, 8'hFF, 1'b0, "R9 outside write");
        check("R9 oe untouched", pad_oe, 8'h00);
        check("R9 out untouched", pad_out, 8'hA5);
        bus_rd(16'd1, 8'h00, 1'b0, "R9 hole1 read");
        bus_rd(16'd3, 8'h00, 1'b0, "R9 hole3 read");
        bus_rd(16'd4, 8'h00, 1'b0, "R9 outside read");
        bus_rd(16'hFFFF, 8'h00, 1'b0, "R9 below base read");

        // R8: external-bus modes
        bus_wr(16'd2, 8'h0F, 1'b0, "R8 setup dir");
        for (int m = 1; m < 4; m++) begin
            mode = 2'(m);
            bus_wr(16'd2, 8'hFF, 1'b1, "R8 remote dir write");
            bus_wr(16'd0, 8'hFF, 1'b1, "R8 remote level write");
            check("R8 oe kept", pad_oe, 8'h0F);
            check("R8 out kept", pad_out, 8'hA5);
            bus_rd(16'd0, 8'h00, 1'b1, "R8 remote level read");
            bus_rd(16'd2, 8'h00, 1'b1, "R8 remote dir read");
            bus_rd(16'd1, 8'h00, 1'b0, "R8 remote hole read");
        end
        mode = 2'b00;
        bus_rd(16'd2, 8'h0F, 1'b0, "R8 dir back in map");
        // level A5 upper pads C3: {C, 5} = C5
        bus_rd(16'd0, 8'hC5, 1'b0, "R4 mixed 0F");

        // R6: relocation
        base_addr = 16'h1200;
        bus_rd(16'd2, 8'h0F, 1'b0, "R6 dir at new base");
        bus_wr(16'd0, 8'h3E, 1'b0, "R6 level at new base");
        check("R6 out after relocated write", pad_out, 8'h3E);
        bus_rd(16'h0040 - 16'h1200 + 16'd2, 8'h00, 1'b0, "R6 old base unmapped");

        @(posedge clk); #1; @(posedge clk); #1;
        if (sb_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule